// File: doc/BRIEF.md
# Timer Run-Control Command Register

This block is the command side of a PWM timer unit. Software writes one byte, and each set bit in it is a single-cycle command, not a stored setting. The commands can start or stop the timer, zero the main counter while it is running, zero a group of three dead-time counters, and arm or disarm the flag that allows the period register to reload. Because no command persists, the byte always reads back as zero.

The block also contains the state that the commands act on, so their effect can be seen at the ports:
- an up-counter that wraps at the active period value;
- a shadow period register that software loads;
- a run flag and a shadow-transfer enable flag;
- three down-counting dead-time channels, each loaded from a shared dead-time value by its own trigger input.

When the counter reaches the period while the transfer is armed, the shadow period value moves into the active period register, and the arming flag clears itself.

Top module: `tmr_cmd_unit`

## Requirements
- R1: After a synchronous reset, all of the following hold: the run flag is 0, the enable flag is 0, the counter is 0, the active and shadow periods both equal PER_RST, every dead-time channel is 0, and the transfer pulse is low.
- R2: A write with bit 1 set makes the run flag 1 from the next cycle on. The counter increases by one on every clock edge at which the run flag was already 1.
- R3: A write with bit 0 set makes the run flag 0, and the counter then holds its value. If bits 0 and 1 are written together, the run flag ends at 0.
- R4: A write with bit 2 set makes the counter 0 on that edge and leaves the run flag unchanged, so a running counter goes on from zero.
- R5: A write with bit 3 set makes all dead-time channels 0 on that edge. This takes priority over a trigger input that arrives in the same cycle.
- R6: A write with bit 6 set makes the enable flag 1. A write with bit 7 set makes it 0 without any period transfer. If both bits are written together, the flag ends at 0.
- R7: Suppose the counter equals the active period at an edge where the run flag and enable flag are both 1 and no counter-zero command is present. Then the counter goes to 0, the shadow value is copied into the active period, the enable flag clears (unless bit 6 is written in the same cycle), and xfer_o is high for the next cycle. The active period changes at no other time.
- R8: When the counter reaches the period while the enable flag is 0, the counter wraps to 0 and the active period keeps its value. The counter never exceeds the active period.
- R9: A trigger on a dead-time channel loads it with dt_value. A channel that is not triggered and is above zero decreases by one each cycle. A channel at zero stays at zero.
- R10: Bits 4 and 5, and any bit written as 0, have no effect on the run flag, the enable flag or the counters. cmd_rdata is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte (bit0 stop, bit1 start, bit2 zero counter, bit3 zero dead-time, bit6 arm, bit7 disarm) |
| cmd_rdata | output | 8 | Read value of the command byte, always 0 |
| shadow_we | input | 1 | Shadow period write strobe |
| shadow_per | input | CNT_W | New shadow period value |
| dt_value | input | DT_W | Common dead-time reload value |
| dt_trig | input | NCH | Per-channel dead-time load trigger |
| run_o | output | 1 | Run flag |
| ste_o | output | 1 | Shadow-transfer enable flag |
| xfer_o | output | 1 | High for one cycle after a period transfer |
| cnt_o | output | CNT_W | Main counter |
| per_o | output | CNT_W | Active period |
| dt_cnt_o | output | NCH*DT_W | Dead-time channels, channel i at bits [i*DT_W +: DT_W] |

## Verification
The assertions check several rules on every cycle:
- the clear-over-set and disarm-over-arm priorities;
- a zero-counter command leaving the counter at 0;
- a dead-time reset beating a trigger;
- channels holding at zero;
- the counter never passing the period;
- the active period changing only on a transfer.

Some behaviour only the bench scenarios can show, by comparing a behavioural model every clock. This covers the exact count sequences, the shadow value moving in at the right wrap, the timing of the transfer pulse, the dead-time countdown values, and reserved-bit writes being ignored.

// File: rtl/tmr_cmd_pkg.sv
package tmr_cmd_pkg;

  localparam int CMD_W       = 8;
  localparam int B_RUN_CLR   = 0;
  localparam int B_RUN_SET   = 1;
  localparam int B_CNT_ZERO  = 2;
  localparam int B_DT_ZERO   = 3;
  localparam int B_ARM       = 6;
  localparam int B_DISARM    = 7;

  typedef struct packed {
    logic run_clr;
    logic run_set;
    logic cnt_zero;
    logic dt_zero;
    logic arm;
    logic disarm;
  } cmd_pulse_t;

  function automatic cmd_pulse_t decode_cmd(input logic we, input logic [CMD_W-1:0] d);
    cmd_pulse_t p;
    p.run_clr  = we & d[B_RUN_CLR];
    p.run_set  = we & d[B_RUN_SET];
    p.cnt_zero = we & d[B_CNT_ZERO];
    p.dt_zero  = we & d[B_DT_ZERO];
    p.arm      = we & d[B_ARM];
    p.disarm   = we & d[B_DISARM];
    return p;
  endfunction

endpackage

// File: rtl/tmr_run_ctrl.sv
module tmr_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic run_set,
  input  logic run_clr,
  input  logic arm,
  input  logic disarm,
  input  logic xfer,
  output logic run_q,
  output logic ste_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (run_clr) begin
      run_q <= 1'b0;
    end else if (run_set) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ste_q <= 1'b0;
    end else if (disarm) begin
      ste_q <= 1'b0;
    end else if (arm) begin
      ste_q <= 1'b1;
    end else if (xfer) begin
      ste_q <= 1'b0;
    end
  end

  AST_RUN_CLR_WINS: assert property (@(posedge clk) disable iff (rst) run_clr |=> !run_q); // R3
  AST_RUN_SET_TAKES: assert property (@(posedge clk) disable iff (rst) (run_set && !run_clr) |=> run_q); // R2
  AST_DISARM_WINS: assert property (@(posedge clk) disable iff (rst) disarm |=> !ste_q); // R6
  AST_XFER_DISARMS: assert property (@(posedge clk) disable iff (rst) (xfer && !arm) |=> !ste_q); // R7

endmodule

// File: rtl/tmr_main_cnt.sv
module tmr_main_cnt #(
  parameter int          CNT_W   = 16,
  parameter int unsigned PER_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ste,
  input  logic             cnt_zero,
  input  logic             shadow_we,
  input  logic [CNT_W-1:0] shadow_in,
  output logic             xfer,
  output logic             xfer_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_q
);

  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);

  logic [CNT_W-1:0] shadow_q;
  logic             at_period;

  assign at_period = (cnt_q == per_q);
  assign xfer      = run & ste & at_period & ~cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_zero) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= at_period ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= PER_INIT;
    end else if (shadow_we) begin
      shadow_q <= shadow_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= PER_INIT;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= xfer;
      if (xfer) begin
        per_q <= shadow_q;
      end
    end
  end

  AST_CNT_ZERO_CMD: assert property (@(posedge clk) disable iff (rst) cnt_zero |=> (cnt_q == '0)); // R4
  AST_CNT_WITHIN_PER: assert property (@(posedge clk) disable iff (rst) cnt_q <= per_q); // R8
  AST_PER_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (rst) !xfer |=> $stable(per_q)); // R7
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst) (!run && !cnt_zero) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/tmr_dt_chan.sv
module tmr_dt_chan #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dt_zero,
  input  logic            trig,
  input  logic [DT_W-1:0] load_val,
  output logic [DT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (dt_zero) begin
      cnt_q <= '0;
    end else if (trig) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DT_RESET_WINS: assert property (@(posedge clk) disable iff (rst) dt_zero |=> (cnt_q == '0)); // R5
  AST_DT_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst) (cnt_q == '0 && !trig) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/tmr_cmd_unit.sv
module tmr_cmd_unit
  import tmr_cmd_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          DT_W    = 8,
  parameter int          NCH     = 3,
  parameter int unsigned PER_RST = 255
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_wdata,
  output logic [CMD_W-1:0]     cmd_rdata,
  input  logic                 shadow_we,
  input  logic [CNT_W-1:0]     shadow_per,
  input  logic [DT_W-1:0]      dt_value,
  input  logic [NCH-1:0]       dt_trig,
  output logic                 run_o,
  output logic                 ste_o,
  output logic                 xfer_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     per_o,
  output logic [NCH*DT_W-1:0]  dt_cnt_o
);

  cmd_pulse_t pulse;
  logic       xfer;

  assign pulse     = decode_cmd(cmd_we, cmd_wdata);
  assign cmd_rdata = '0;

  tmr_run_ctrl u_run (
    .clk     (clk),
    .rst     (rst),
    .run_set (pulse.run_set),
    .run_clr (pulse.run_clr),
    .arm     (pulse.arm),
    .disarm  (pulse.disarm),
    .xfer    (xfer),
    .run_q   (run_o),
    .ste_q   (ste_o)
  );

  tmr_main_cnt #(
    .CNT_W   (CNT_W),
    .PER_RST (PER_RST)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run_o),
    .ste       (ste_o),
    .cnt_zero  (pulse.cnt_zero),
    .shadow_we (shadow_we),
    .shadow_in (shadow_per),
    .xfer      (xfer),
    .xfer_q    (xfer_o),
    .cnt_q     (cnt_o),
    .per_q     (per_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dt
    tmr_dt_chan #(
      .DT_W (DT_W)
    ) u_dt (
      .clk      (clk),
      .rst      (rst),
      .dt_zero  (pulse.dt_zero),
      .trig     (dt_trig[ch]),
      .load_val (dt_value),
      .cnt_q    (dt_cnt_o[ch*DT_W +: DT_W])
    );
  end

  AST_RSV_NO_RUN_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && ((cmd_wdata & 8'hCF) == 8'h00)) |=> $stable(run_o)); // R10

endmodule

// File: tb/tmr_cmd_unit_bench.sv
`timescale 1ns/1ps
module tmr_cmd_unit_bench;

  localparam int CW  = 8;
  localparam int DW  = 4;
  localparam int NC  = 3;
  localparam int PRS = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_we = 1'b0;
  logic [7:0]    cmd_wdata = '0;
  logic [7:0]    cmd_rdata;
  logic          shadow_we = 1'b0;
  logic [CW-1:0] shadow_per = '0;
  logic [DW-1:0] dt_value = '0;
  logic [NC-1:0] dt_trig = '0;
  logic          run_o, ste_o, xfer_o;
  logic [CW-1:0] cnt_o, per_o;
  logic [NC*DW-1:0] dt_cnt_o;

  always #2.5 clk = ~clk;

  tmr_cmd_unit #(.CNT_W(CW), .DT_W(DW), .NCH(NC), .PER_RST(PRS)) u_tmr_cmd_unit (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .shadow_we(shadow_we), .shadow_per(shadow_per), .dt_value(dt_value), .dt_trig(dt_trig),
    .run_o(run_o), .ste_o(ste_o), .xfer_o(xfer_o), .cnt_o(cnt_o), .per_o(per_o), .dt_cnt_o(dt_cnt_o)
  );

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_run = 0, m_ste = 0, m_cnt = 0, m_per = PRS, m_sh = PRS, m_xfer = 0;
  int m_dt[NC] = '{default: 0};

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ste = 0; m_cnt = 0; m_per = PRS; m_sh = PRS; m_xfer = 0;
      foreach (m_dt[i]) m_dt[i] = 0;
    end else begin
      bit stop, go, zc, zd, arm, dis, hit;
      int n_cnt;
      stop = cmd_we && cmd_wdata[0];
      go   = cmd_we && cmd_wdata[1];
      zc   = cmd_we && cmd_wdata[2];
      zd   = cmd_we && cmd_wdata[3];
      arm  = cmd_we && cmd_wdata[6];
      dis  = cmd_we && cmd_wdata[7];
      hit  = (m_run != 0) && (m_ste != 0) && !zc && (m_cnt == m_per);
      if (zc) n_cnt = 0;
      else if (m_run != 0) n_cnt = (m_cnt == m_per) ? 0 : m_cnt + 1;
      else n_cnt = m_cnt;
      m_cnt = n_cnt;
      if (hit) m_per = m_sh;
      if (shadow_we) m_sh = int'(shadow_per);
      if (stop) m_run = 0; else if (go) m_run = 1;
      if (dis) m_ste = 0; else if (arm) m_ste = 1; else if (hit) m_ste = 0;
      m_xfer = hit ? 1 : 0;
      foreach (m_dt[i]) begin
        if (zd) m_dt[i] = 0;
        else if (dt_trig[i]) m_dt[i] = int'(dt_value);
        else if (m_dt[i] > 0) m_dt[i] = m_dt[i] - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(run_o === m_run[0], "run", int'(run_o), m_run);
      chk(ste_o === m_ste[0], "ste", int'(ste_o), m_ste);
      chk(xfer_o === m_xfer[0], "xfer", int'(xfer_o), m_xfer);
      chk(cnt_o === CW'(m_cnt), "cnt", int'(cnt_o), m_cnt);
      chk(per_o === CW'(m_per), "per", int'(per_o), m_per);
      chk(cmd_rdata === 8'h00, "rdata R10", int'(cmd_rdata), 0);
      for (int i = 0; i < NC; i++)
        chk(dt_cnt_o[i*DW +: DW] === DW'(m_dt[i]), "dt", int'(dt_cnt_o[i*DW +: DW]), m_dt[i]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    cur_req = "R1";
    chk(per_o == CW'(PRS) && cnt_o == 0 && !run_o, "reset values R1", int'(per_o), PRS);
    rst = 1'b0;
    idle(2);

    cur_req = "R2";
    cmd(8'h02);
    chk(run_o == 1'b1, "start R2", int'(run_o), 1);
    idle(6);

    cur_req = "R3";
    cmd(8'h01);
    chk(run_o == 1'b0, "stop R3", int'(run_o), 0);
    idle(3);
    cmd(8'h03);
    chk(run_o == 1'b0, "clear wins R3", int'(run_o), 0);

    cur_req = "R10";
    cmd(8'h30);
    cmd(8'h00);
    chk(run_o == 1'b0 && ste_o == 1'b0, "reserved ignored R10", int'(run_o), 0);

    cur_req = "R4";
    cmd(8'h02);
    idle(4);
    cmd(8'h04);
    chk(cnt_o == 0 && run_o, "zero while running R4", int'(cnt_o), 0);
    idle(3);
    chk(cnt_o == 3, "continues from zero R4", int'(cnt_o), 3);

    cur_req = "R8";
    idle(30);

    cur_req = "R6";
    cmd(8'h40);
    chk(ste_o == 1'b1, "arm R6", int'(ste_o), 1);
    cmd(8'h80);
    chk(ste_o == 1'b0, "disarm R6", int'(ste_o), 0);
    cmd(8'h40);
    cmd(8'hC0);
    chk(ste_o == 1'b0, "disarm wins R6", int'(ste_o), 0);
    idle(25);
    chk(per_o == CW'(PRS), "no transfer after disarm R6", int'(per_o), PRS);

    cur_req = "R7";
    shadow_we = 1'b1; shadow_per = 8'd7;
    @(negedge clk);
    shadow_we = 1'b0;
    cmd(8'h40);
    idle(26);
    chk(per_o == 8'd7, "period reloaded R7", int'(per_o), 7);
    chk(ste_o == 1'b0, "arm auto-cleared R7", int'(ste_o), 0);
    idle(20);

    cur_req = "R9";
    dt_value = 4'd5; dt_trig = 3'b101;
    @(negedge clk);
    dt_trig = 3'b000;
    idle(2);
    dt_trig = 3'b010;
    @(negedge clk);
    dt_trig = 3'b000;
    idle(8);
    chk(dt_cnt_o == '0, "channels hold at zero R9", int'(dt_cnt_o), 0);

    cur_req = "R5";
    dt_value = 4'd9; dt_trig = 3'b111;
    @(negedge clk);
    dt_trig = 3'b000;
    idle(2);
    cmd(8'h08);
    chk(dt_cnt_o == '0, "dead-time zero R5", int'(dt_cnt_o), 0);
    dt_trig = 3'b111;
    cmd(8'h08);
    dt_trig = 3'b000;
    chk(dt_cnt_o == '0, "zero beats trigger R5", int'(dt_cnt_o), 0);
    idle(3);

    cur_req = "R1";
    rst = 1'b1;
    idle(2);
    chk(run_o == 1'b0 && per_o == CW'(PRS) && dt_cnt_o == '0, "re-reset R1", int'(per_o), PRS);
    rst = 1'b0;
    idle(2);
    finish_run();
  end

endmodule